// File: doc/BRIEF.md
# Backlight PWM Generator

This block produces one pulse-width-modulated output for a display backlight. Software programs it through a byte-wide synchronous register port. A control register holds a 7-bit prescaler code and an output-enable bit. A level register holds the 8-bit duty. A separate backlight-enable register gates the output as well. The prescaler divides the base clock by code+1, and each PWM period is 256 divided ticks long. The output is high during the first `level` ticks of every period.

New duty and divider values are held in shadow registers. They are taken over only at a period boundary, so a running waveform never produces a runt pulse. Software changes the divider while the backlight enable is off and then turns it back on. Whenever the output goes from disabled to enabled, the prescaler and the period counter start again from zero.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset all three registers read 0x00 and `pwm_out` is low.
- R2: Offset 0x4B (control: bit 7 output enable, bits 6:0 prescaler code), offset 0x4E (duty level) and offset 0x51 (backlight enable, bit 0) each read back the exact byte last written.
- R3: A write to any other offset changes no register, and a read of any other offset returns 0x00.
- R4: `pwm_out` is low whenever control bit 7 or backlight-enable bit 0 is 0.
- R5: While enabled, one PWM period lasts 256*(code+1) base-clock cycles, and the next period starts high when the level is nonzero.
- R6: Within a period the output is high for exactly level*(code+1) cycles at the start of the period and low for the rest. Level 0 gives a constant low, and level 0xFF leaves one low step per period.
- R7: A duty or prescaler write made while enabled takes effect at the first period boundary after the write cycle. A write that lands on the boundary cycle itself takes effect one period later.
- R8: When the output becomes enabled, counting restarts from zero using the register values present at that moment, including a prescaler code written while disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Register offset for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Gated PWM output |

## Verification
A register write and a period boundary can fall in the same clock edge. The bench provokes this by counting cycles from the enabling write, so that a duty write strikes exactly the last cycle of the first period. It then judges the high-time totals of three consecutive periods: the old level must hold for two periods and the new level must appear in the third. A second run places the write mid-period, and the new level must then appear one period earlier. Prescaler changes are checked the same way, by the length of the period that follows the change.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DIV_W  = 7;
  localparam int unsigned CNT_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h4B;
  localparam logic [ADDR_W-1:0] OFS_DUTY = 8'h4E;
  localparam logic [ADDR_W-1:0] OFS_BLEN = 8'h51;

  typedef struct packed {
    logic             out_en;
    logic [DIV_W-1:0] div;
  } ctrl_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output ctrl_t             ctrl,
  output logic [REG_W-1:0]  duty,
  output logic [REG_W-1:0]  blen
);
  localparam int unsigned NREG = 3;
  localparam logic [ADDR_W-1:0] OFS [NREG] = '{OFS_CTRL, OFS_DUTY, OFS_BLEN};

  logic [REG_W-1:0] reg_q [NREG];
  logic [NREG-1:0]  hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] reg_d;
    assign hit[g] = (addr == OFS[g]);
    always_comb begin
      reg_d = reg_q[g];
      if (we && hit[g]) reg_d = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[g] <= '0;
      else        reg_q[g] <= reg_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rdata = reg_q[i];
    end
  end

  assign ctrl = ctrl_t'(reg_q[0]);
  assign duty = reg_q[1];
  assign blen = reg_q[2];

  // R3: a write to an unmapped offset leaves every register unchanged
  a_r3_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (hit == '0)) |=> ($stable(reg_q[0]) && $stable(reg_q[1]) && $stable(reg_q[2])));
endmodule

// File: rtl/bl_pwm_prescale.sv
module bl_pwm_prescale
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)                cnt_d = '0;
    else if (cnt_q == limit) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == limit);

  // R5: the prescaler count never passes the active limit
  a_r5_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
  // R8: an idle prescaler is at zero when it next runs
  a_r8_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [REG_W-1:0] duty_live,
  input  logic [DIV_W-1:0] div_live,
  output logic [DIV_W-1:0] div_act,
  output logic             pwm_hi
);
  logic [CNT_W-1:0] pcnt_q, pcnt_d;
  logic [REG_W-1:0] duty_q, duty_d;
  logic [DIV_W-1:0] div_q,  div_d;
  logic             boundary, load;

  assign boundary = tick && (pcnt_q == {CNT_W{1'b1}});
  assign load     = !run || boundary;

  always_comb begin
    pcnt_d = pcnt_q;
    if (!run)      pcnt_d = '0;
    else if (tick) pcnt_d = pcnt_q + 1'b1;
    duty_d = load ? duty_live : duty_q;
    div_d  = load ? div_live  : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      duty_q <= '0;
      div_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      duty_q <= duty_d;
      div_q  <= div_d;
    end
  end

  assign div_act = div_q;
  assign pwm_hi  = run && (CNT_W'(pcnt_q) < CNT_W'(duty_q));

  // R7: shadow values are held between period boundaries
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> ($stable(duty_q) && $stable(div_q)));
  // R8: the period counter is at zero after any idle cycle
  a_r8_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt_q == '0));
  // R6: a zero level never drives the output high
  a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_hi);
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  ctrl_t            ctrl;
  logic [REG_W-1:0] duty, blen;
  logic [DIV_W-1:0] div_act;
  logic             active, tick, pwm_hi;

  bl_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .ctrl(ctrl), .duty(duty), .blen(blen)
  );

  assign active = ctrl.out_en && blen[0];

  bl_pwm_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(active), .limit(div_act), .tick(tick)
  );

  bl_pwm_core u_core (
    .clk(clk), .rst_n(rst_n), .run(active), .tick(tick),
    .duty_live(duty), .div_live(ctrl.div), .div_act(div_act), .pwm_hi(pwm_hi)
  );

  assign pwm_out = pwm_hi;

  // R4: either enable low forces the output low
  a_r4_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.out_en || !blen[0]) |-> !pwm_out);
endmodule

// File: tb/bl_pwm_top_tb_top.sv
`timescale 1ns/1ps
module bl_pwm_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bl_pwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic int per_len(int dv);
    return 256 * (dv + 1);
  endfunction
  function automatic int hi_len(int dv, int lv);
    return lv * (dv + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Program with enable off, then enable; returns at the first sample after enabling.
  task automatic arm(int dv, int lv);
    wr(8'h51, 8'h00);
    wr(8'h4B, 8'(8'h80 | dv));
    wr(8'h4E, 8'(lv));
    wr(8'h51, 8'h01);
  endtask

  // R5 R6 R8: one full period measured from the enabling edge
  task automatic run_check(int dv, int lv, string tag);
    int p = per_len(dv);
    int hi = 0;
    int first_low = -1;
    int wrap_s = 0;
    arm(dv, lv);
    for (int i = 0; i <= p; i++) begin
      if (i < p) begin
        if (pwm_out) hi++;
        else if (first_low < 0) first_low = i;
      end else wrap_s = pwm_out;
      @(negedge clk);
    end
    if (first_low < 0) first_low = p;
    check({"R6 high count ", tag}, hi, hi_len(dv, lv));
    check({"R8 restart/contiguous high ", tag}, first_low, hi_len(dv, lv));
    check({"R5 next period start ", tag}, wrap_s, (lv != 0) ? 1 : 0);
  endtask

  // R7: write at sample index widx, then count highs over three windows
  task automatic chg_test(int dv, int lv, int widx, logic [7:0] a, logic [7:0] d,
                          int w0, int w1, int w2, int e0, int e1, int e2, string tag);
    int h0 = 0, h1 = 0, h2 = 0;
    arm(dv, lv);
    for (int i = 0; i < w0 + w1 + w2; i++) begin
      if (pwm_out) begin
        if (i < w0) h0++;
        else if (i < w0 + w1) h1++;
        else h2++;
      end
      if (i == widx) begin
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      end else bus_we = 1'b0;
      @(negedge clk);
    end
    bus_we = 1'b0;
    check({"R7 window0 ", tag}, h0, e0);
    check({"R7 window1 ", tag}, h1, e1);
    check({"R7 window2 ", tag}, h2, e2);
  endtask

  initial begin
    #(20 * 200000 - 100);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, lowcnt;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h4B, v); check("R1 ctrl reset", v, 0);
    rd(8'h4E, v); check("R1 duty reset", v, 0);
    rd(8'h51, v); check("R1 blen reset", v, 0);
    check("R1 output reset", pwm_out, 0);

    // R2 readback
    wr(8'h4B, 8'h3C); wr(8'h4E, 8'hA5); wr(8'h51, 8'h5A);
    rd(8'h4B, v); check("R2 ctrl readback", v, 8'h3C);
    rd(8'h4E, v); check("R2 duty readback", v, 8'hA5);
    rd(8'h51, v); check("R2 blen readback", v, 8'h5A);

    // R3 unmapped offsets
    wr(8'h4C, 8'hFF); wr(8'h00, 8'hFF); wr(8'h50, 8'h01);
    rd(8'h4B, v); check("R3 ctrl untouched", v, 8'h3C);
    rd(8'h4E, v); check("R3 duty untouched", v, 8'hA5);
    rd(8'h51, v); check("R3 blen untouched", v, 8'h5A);
    rd(8'h4C, v); check("R3 unmapped read", v, 0);
    rd(8'hFF, v); check("R3 unmapped read top", v, 0);

    // R4 gating: bit7 set, blen bit0 clear, full duty
    wr(8'h4B, 8'h80); wr(8'h4E, 8'hFF);
    lowcnt = 0;
    for (int i = 0; i < 300; i++) begin
      if (pwm_out) lowcnt++;
      @(negedge clk);
    end
    check("R4 blen off keeps low", lowcnt, 0);

    // directed corners
    run_check(0, 0, "div0 lvl0");
    run_check(0, 255, "div0 lvl255");
    run_check(127, 128, "div127 lvl128");
    run_check(3, 1, "div3 lvl1");

    // R4 gating while running: clear bit7
    arm(0, 255);
    wr(8'h4B, 8'h00);
    lowcnt = 0;
    for (int i = 0; i < 300; i++) begin
      if (pwm_out) lowcnt++;
      @(negedge clk);
    end
    check("R4 out_en off keeps low", lowcnt, 0);

    // random trials
    for (int t = 0; t < 8; t++) begin
      int dv = $urandom % 16;
      int lv = $urandom % 256;
      run_check(dv, lv, $sformatf("rand%0d", t));
    end

    // R7 duty write exactly on the boundary edge: old level holds one extra period
    chg_test(1, 40, 511, 8'h4E, 8'd200, 512, 512, 512, 80, 80, 400, "duty at boundary");
    // R7 duty write mid-period
    chg_test(1, 40, 100, 8'h4E, 8'd10, 512, 512, 512, 80, 20, 20, "duty mid");
    // R7 prescaler write mid-period: period 0 keeps code 1, later periods use code 3
    chg_test(1, 64, 50, 8'h4B, 8'h83, 512, 1024, 1024, 128, 256, 256, "div mid");

    wr(8'h51, 8'h00);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule